// File: doc/BRIEF.md
# IMA Control Cell Overhead Octet Generator

This block produces the five group and link overhead octets that sit near the start of an inverse-multiplexing control cell: the stuff indication, the change counter, the group identifier, the group status and control octet, and the transmit timing octet. A link transmitter pulses `cell_req` each time it reaches a control-cell slot. The block then streams the five octets, one per clock, with a valid flag and a last flag on the final octet. Cell framing, header error control and the remaining overhead octets are produced elsewhere. A change in any of those other octets is signalled to this block on `chg_pulse`.

Two pieces of state run across successive control cells. The first is a stuff-indication countdown. A stuff request carries a lead distance, and the block counts the warning code down cell by cell. It always sends the mandatory "next location" code and then the two "event" codes before it returns to idle. The second is an 8-bit change counter. It steps by one in the first cell whose group-level content differs from the previous cell, or in the first cell after an external change pulse. This puts the new field values and the new count in the same cell.

The configuration inputs are registered once before use. Every cell carries a consistent snapshot of the configuration, taken at the clock edge that accepts the request.

Top module: `ima_icp_ovh_gen`

## Requirements
- R1: After reset, `ovh_valid` and `ovh_last` are 0. The stuff code is 111, the change counter is 0, and the reference copies of octets 2 to 4 are all zero.
- R2: A `cell_req` sampled while no cell is in progress, or while the fifth octet of the previous cell is on the output, is accepted. Octets 0 to 4 then appear on the five following cycles with `ovh_valid` high, and `ovh_last` is high only with octet 4. A `cell_req` sampled while octets 0 to 3 of a cell are on the output is ignored.
- R3: Octet 0 is {5'b00000, code}. The code is 111 when no stuff event is pending.
- R4: A stuff request with lead 4 gives the codes 100, 011, 010, 001, 000, 000 on the next six cells, and 111 after that.
- R5: A lead L from 1 to 3 starts the countdown at the 3-bit value L. A lead of 0 is treated as 1. A lead above the LEAD_MAX parameter (default 4) is treated as LEAD_MAX. Code 001 and two cells of 000 are never skipped.
- R6: A stuff request is ignored while a countdown is in progress, up to and including the edge that accepts the second 000 cell. A request sampled on the same edge as an idle cell's acceptance leaves that cell at 111 and starts the countdown from the next cell.
- R7: Octet 1 is the change count. It is one higher than in the previous cell if octet 2, 3 or 4 differs from the previous cell, or if `chg_pulse` was high at any edge since the previous acceptance, including the accepting edge. Otherwise it is equal. Several changes between two cells give a single step.
- R8: The change count wraps from 255 to 0.
- R9: Octet 2 is the 8-bit group identifier.
- R10: Octet 3 is {status[3:0], symmetry[1:0], frame length[1:0]}, with status in bits 7-4, symmetry in bits 3-2 and frame length in bits 1-0.
- R11: Octet 4 is {2'b00, clock mode, reference link ID[4:0]}, with bit 5 = 1 meaning common clocking.
- R12: A cell carries the configuration inputs as sampled on the clock edge before the one that accepts its request. A change applied on the accepting edge itself first appears in the following cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_req | input | 1 | Request for one control cell's overhead octets |
| stuff_req | input | 1 | Schedule a stuff event |
| stuff_lead | input | 3 | Distance in control cells to the stuff event |
| chg_pulse | input | 1 | A change occurred in an overhead octet handled elsewhere |
| group_id | input | 8 | Group identifier |
| grp_state | input | 4 | Group status code |
| symm_mode | input | 2 | Symmetry mode code |
| frame_len_sel | input | 2 | Frame length code |
| clk_mode_common | input | 1 | 1 = common transmit clock, 0 = independent |
| ref_link_id | input | 5 | Transmit link ID of the timing reference link |
| ovh_data | output | 8 | Overhead octet |
| ovh_valid | output | 1 | Octet valid |
| ovh_last | output | 1 | Final (timing) octet of the cell |

## Verification
The bench builds the block with LEAD_MAX at its default of 4. With that value the full six-cell countdown is reachable, and so are the clamp of an oversized lead (7 becomes 4) and of a zero lead (0 becomes 1). Stuff requests are placed mid-countdown, between the two event cells, and on the same edge as a cell acceptance. Back-to-back cells and requests issued while a cell is being sent are also covered. More than 256 cells are sent, each with a change pulse, so the counter wrap at 255 is exercised.

// File: rtl/ima_ovh_pkg.sv
package ima_ovh_pkg;

  localparam int OCT_W   = 8;
  localparam int NUM_OCT = 5;
  localparam int CODE_W  = 3;
  localparam int CNT_W   = 8;
  localparam int GID_W   = 8;
  localparam int STAT_W  = 4;
  localparam int SYM_W   = 2;
  localparam int FLEN_W  = 2;
  localparam int LID_W   = 5;
  localparam int GRP_OCT = 3;

  localparam logic [CODE_W-1:0] CODE_IDLE = 3'b111;
  localparam logic [CODE_W-1:0] CODE_EVT  = 3'b000;
  localparam logic [CODE_W-1:0] CODE_NEXT = 3'b001;

  typedef struct packed {
    logic [GID_W-1:0]  gid;
    logic [STAT_W-1:0] status;
    logic [SYM_W-1:0]  symm;
    logic [FLEN_W-1:0] flen;
    logic              common_clk;
    logic [LID_W-1:0]  trl;
  } grp_cfg_t;

  // Octet 0: zero padding above the stuff code.
  function automatic logic [OCT_W-1:0] f_lsi_octet(input logic [CODE_W-1:0] code);
    return {{(OCT_W-CODE_W){1'b0}}, code};
  endfunction

  // Octet 3: status high nibble, symmetry, frame length.
  function automatic logic [OCT_W-1:0] f_gsc_octet(input grp_cfg_t c);
    return {c.status, c.symm, c.flen};
  endfunction

  // Octet 4: two zero bits, clock mode, reference link.
  function automatic logic [OCT_W-1:0] f_timing_octet(input grp_cfg_t c);
    return {2'b00, c.common_clk, c.trl};
  endfunction

  // Starting countdown code for a requested lead, clamped to 1..cap.
  function automatic logic [CODE_W-1:0] f_lead_code(input logic [CODE_W-1:0] lead,
                                                    input int cap);
    int l;
    l = int'(lead);
    if (l < 1)   l = 1;
    if (l > cap) l = cap;
    return CODE_W'(l);
  endfunction

endpackage

// File: rtl/ima_stuff_seq.sv
module ima_stuff_seq
  import ima_ovh_pkg::*;
#(
  parameter int LEAD_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_start,
  input  logic              stuff_req,
  input  logic [CODE_W-1:0] stuff_lead,
  output logic [CODE_W-1:0] cur_code
);

  localparam int LEAD_CAP = (LEAD_MAX > 4) ? 4 : ((LEAD_MAX < 1) ? 1 : LEAD_MAX);

  logic [CODE_W-1:0] code_q, code_n;
  logic              second_q, second_n;
  logic              seq_idle;
  logic              load_evt;

  assign seq_idle = (code_q == CODE_IDLE);
  assign load_evt = stuff_req && seq_idle;
  assign cur_code = code_q;

  always_comb begin
    code_n   = code_q;
    second_n = second_q;
    if (cell_start && !seq_idle) begin
      if (code_q == CODE_EVT) begin
        if (second_q) begin
          code_n   = CODE_IDLE;
          second_n = 1'b0;
        end else begin
          second_n = 1'b1;
        end
      end else begin
        code_n = code_q - 3'd1;
      end
    end
    if (load_evt) begin
      code_n   = f_lead_code(stuff_lead, LEAD_CAP);
      second_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= CODE_IDLE;
      second_q <= 1'b0;
    end else begin
      code_q   <= code_n;
      second_q <= second_n;
    end
  end

  // R4
  next_then_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start && code_q == CODE_NEXT |=> code_q == CODE_EVT && !second_q);

  // R4
  evt_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start && code_q == CODE_EVT && !second_q |=> code_q == CODE_EVT && second_q);

  // R6
  evt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start && second_q |=> code_q == CODE_IDLE);

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_idle && !cell_start |=> $stable(code_q) && $stable(second_q));

  // R5
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> code_q != CODE_IDLE && code_q != CODE_EVT);

  // R3
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_q == CODE_IDLE || int'(code_q) <= LEAD_CAP);

endmodule

// File: rtl/ima_chg_count.sv
module ima_chg_count
  import ima_ovh_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cell_start,
  input  logic                     chg_pulse,
  input  logic [GRP_OCT*OCT_W-1:0] grp_octets,
  output logic [CNT_W-1:0]         cnt_emit
);

  logic [CNT_W-1:0]         cnt_q;
  logic [GRP_OCT*OCT_W-1:0] ref_q;
  logic                     pend_q;
  logic                     grp_diff;
  logic                     chg_seen;

  assign grp_diff = (grp_octets != ref_q);
  assign chg_seen = grp_diff || pend_q || chg_pulse;
  assign cnt_emit = chg_seen ? cnt_q + CNT_W'(1) : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ref_q  <= '0;
      pend_q <= 1'b0;
    end else if (cell_start) begin
      cnt_q  <= cnt_emit;
      ref_q  <= grp_octets;
      pend_q <= 1'b0;
    end else if (chg_pulse) begin
      pend_q <= 1'b1;
    end
  end

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start && !chg_seen |=> cnt_q == $past(cnt_q));

  // R7 R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start && chg_seen |=> cnt_q == $past(cnt_q) + 8'd1);

  // R7
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pulse && !cell_start |=> pend_q);

  // R7
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_start |=> $stable(cnt_q));

endmodule

// File: rtl/ima_ovh_ser.sv
module ima_ovh_ser
  import ima_ovh_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cell_req,
  input  logic [NUM_OCT*OCT_W-1:0] oct_in,
  output logic                     cell_start,
  output logic [OCT_W-1:0]         ovh_data,
  output logic                     ovh_valid,
  output logic                     ovh_last
);

  localparam int IDX_W = $clog2(NUM_OCT + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OCT - 1);

  logic [NUM_OCT*OCT_W-1:0] snap_q;
  logic [IDX_W-1:0]         idx_q;
  logic                     in_cell;

  assign in_cell    = (idx_q != '0);
  assign cell_start = cell_req && !in_cell;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q    <= '0;
      idx_q     <= '0;
      ovh_data  <= '0;
      ovh_valid <= 1'b0;
      ovh_last  <= 1'b0;
    end else if (cell_start) begin
      snap_q    <= oct_in;
      ovh_data  <= oct_in[OCT_W-1:0];
      ovh_valid <= 1'b1;
      ovh_last  <= 1'b0;
      idx_q     <= IDX_W'(1);
    end else if (in_cell) begin
      ovh_data  <= snap_q[idx_q*OCT_W +: OCT_W];
      ovh_valid <= 1'b1;
      ovh_last  <= (idx_q == LAST_IDX);
      idx_q     <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
    end else begin
      ovh_valid <= 1'b0;
      ovh_last  <= 1'b0;
    end
  end

  // R2
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovh_last |-> ovh_valid);

  // R2
  stream_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovh_valid && !ovh_last |=> ovh_valid);

  // R2
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |=> ovh_valid && !ovh_last);

  // R2
  busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_req && ovh_valid && !ovh_last |-> !cell_start);

endmodule

// File: rtl/ima_icp_ovh_gen.sv
module ima_icp_ovh_gen
  import ima_ovh_pkg::*;
#(
  parameter int LEAD_MAX = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cell_req,
  input  logic        stuff_req,
  input  logic [2:0]  stuff_lead,
  input  logic        chg_pulse,
  input  logic [7:0]  group_id,
  input  logic [3:0]  grp_state,
  input  logic [1:0]  symm_mode,
  input  logic [1:0]  frame_len_sel,
  input  logic        clk_mode_common,
  input  logic [4:0]  ref_link_id,
  output logic [7:0]  ovh_data,
  output logic        ovh_valid,
  output logic        ovh_last
);

  grp_cfg_t                 cfg_q;
  logic                     cell_start;
  logic [CODE_W-1:0]        stuff_code;
  logic [CNT_W-1:0]         cnt_emit;
  logic [GRP_OCT*OCT_W-1:0] grp_octets;
  logic [NUM_OCT*OCT_W-1:0] cell_octets;

  // R12: one register stage on the configuration inputs.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q.gid        <= group_id;
      cfg_q.status     <= grp_state;
      cfg_q.symm       <= symm_mode;
      cfg_q.flen       <= frame_len_sel;
      cfg_q.common_clk <= clk_mode_common;
      cfg_q.trl        <= ref_link_id;
    end
  end

  assign grp_octets  = {f_timing_octet(cfg_q), f_gsc_octet(cfg_q), cfg_q.gid};
  assign cell_octets = {grp_octets, cnt_emit, f_lsi_octet(stuff_code)};

  ima_stuff_seq #(
    .LEAD_MAX (LEAD_MAX)
  ) u_stuff (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_start (cell_start),
    .stuff_req  (stuff_req),
    .stuff_lead (stuff_lead),
    .cur_code   (stuff_code)
  );

  ima_chg_count u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_start (cell_start),
    .chg_pulse  (chg_pulse),
    .grp_octets (grp_octets),
    .cnt_emit   (cnt_emit)
  );

  ima_ovh_ser u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_req   (cell_req),
    .oct_in     (cell_octets),
    .cell_start (cell_start),
    .ovh_data   (ovh_data),
    .ovh_valid  (ovh_valid),
    .ovh_last   (ovh_last)
  );

  // R3
  lsi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |=> ovh_data[7:3] == 5'b00000);

  // R11
  timing_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovh_last |-> ovh_data[7:6] == 2'b00);

endmodule

// File: tb/ima_icp_ovh_gen_bench.sv
module ima_icp_ovh_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cell_req = 1'b0;
  logic       stuff_req = 1'b0;
  logic [2:0] stuff_lead = 3'd0;
  logic       chg_pulse = 1'b0;
  logic [7:0] group_id = 8'd0;
  logic [3:0] grp_state = 4'd0;
  logic [1:0] symm_mode = 2'd0;
  logic [1:0] frame_len_sel = 2'd0;
  logic       clk_mode_common = 1'b0;
  logic [4:0] ref_link_id = 5'd0;
  logic [7:0] ovh_data;
  logic       ovh_valid;
  logic       ovh_last;

  always #10 clk = ~clk;

  ima_icp_ovh_gen u_ima_icp_ovh_gen (
    .clk             (clk),
    .rst_n           (rst_n),
    .cell_req        (cell_req),
    .stuff_req       (stuff_req),
    .stuff_lead      (stuff_lead),
    .chg_pulse       (chg_pulse),
    .group_id        (group_id),
    .grp_state       (grp_state),
    .symm_mode       (symm_mode),
    .frame_len_sel   (frame_len_sel),
    .clk_mode_common (clk_mode_common),
    .ref_link_id     (ref_link_id),
    .ovh_data        (ovh_data),
    .ovh_valid       (ovh_valid),
    .ovh_last        (ovh_last)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench model
  int m_code = 7;
  bit m_second = 0;
  int m_cnt = 0;
  bit m_pend = 0;
  int m_ref2 = 0, m_ref3 = 0, m_ref4 = 0;
  int m_gid = 0, m_st = 0, m_sym = 0, m_fl = 0, m_ctc = 0, m_trl = 0;
  bit armed = 0;
  int coinc_lead = -1;
  bit saw_wrap = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic int clamp_lead(input int lead);
    if (lead == 0) return 1;
    if (lead > 4) return 4;
    return lead;
  endfunction

  task automatic set_cfg(input int gid, input int st, input int sym, input int fl,
                         input int ctc, input int trl);
    @(negedge clk);
    group_id = 8'(gid); grp_state = 4'(st); symm_mode = 2'(sym);
    frame_len_sel = 2'(fl); clk_mode_common = 1'(ctc); ref_link_id = 5'(trl);
    m_gid = gid; m_st = st; m_sym = sym; m_fl = fl; m_ctc = ctc; m_trl = trl;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_chg();
    @(negedge clk); chg_pulse = 1'b1;
    @(negedge clk); chg_pulse = 1'b0;
    m_pend = 1;
  endtask

  task automatic req_stuff(input int lead);
    @(negedge clk); stuff_req = 1'b1; stuff_lead = 3'(lead);
    @(negedge clk); stuff_req = 1'b0;
    if (m_code == 7) begin m_code = clamp_lead(lead); m_second = 0; end
  endtask

  // One cell: compute expectation, request, capture five octets.
  task automatic do_cell(input string t0, input bit poke, input bit chain);
    int e[5];
    int g2, g3, g4, prev;
    bit was_idle;
    g2 = m_gid;
    g3 = m_st * 16 + m_sym * 4 + m_fl;
    g4 = m_ctc * 32 + m_trl;
    e[0] = m_code;
    prev = m_cnt;
    if (m_pend || g2 != m_ref2 || g3 != m_ref3 || g4 != m_ref4) m_cnt = (m_cnt + 1) % 256;
    e[1] = m_cnt; e[2] = g2; e[3] = g3; e[4] = g4;
    m_ref2 = g2; m_ref3 = g3; m_ref4 = g4; m_pend = 0;
    was_idle = (m_code == 7);
    if (m_code >= 1 && m_code <= 4) m_code = m_code - 1;
    else if (m_code == 0) begin
      if (m_second) begin m_code = 7; m_second = 0; end else m_second = 1;
    end
    if (!armed) begin
      @(negedge clk); cell_req = 1'b1;
      if (coinc_lead >= 0) begin stuff_req = 1'b1; stuff_lead = 3'(coinc_lead); end
    end
    armed = 0;
    @(negedge clk); cell_req = 1'b0; stuff_req = 1'b0;
    if (coinc_lead >= 0 && was_idle) begin m_code = clamp_lead(coinc_lead); m_second = 0; end
    coinc_lead = -1;
    for (int i = 0; i < 5; i++) begin
      if (i > 0) @(negedge clk);
      check("R2", $sformatf("valid octet %0d", i), int'(ovh_valid), 1);
      check("R2", $sformatf("last octet %0d", i), int'(ovh_last), (i == 4) ? 1 : 0);
      case (i)
        0: check(t0, "stuff octet", int'(ovh_data), e[0]);
        1: check((prev == 255 && e[1] == 0) ? "R8" : "R7", "count octet", int'(ovh_data), e[1]);
        2: check("R9", "group id octet", int'(ovh_data), e[2]);
        3: check("R10", "status octet", int'(ovh_data), e[3]);
        default: check("R11", "timing octet", int'(ovh_data), e[4]);
      endcase
      if (prev == 255 && e[1] == 0) saw_wrap = 1;
      if (poke && i == 1) cell_req = 1'b1;
      if (poke && i == 2) cell_req = 1'b0;
      if (chain && i == 4) begin cell_req = 1'b1; armed = 1; end
    end
    if (poke) begin
      @(negedge clk);
      check("R2", "valid after ignored request", int'(ovh_valid), 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", int'(ovh_valid), 0);
    check("R1", "last in reset", int'(ovh_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", int'(ovh_valid), 0);
    do_cell("R1", 0, 0);
  endtask

  task automatic t_fields();
    set_cfg(8'hA5, 4'b1010, 2'b01, 2'b11, 1, 17);
    do_cell("R3", 0, 0);
    do_cell("R3", 0, 0);
    set_cfg(8'h3C, 4'b0010, 2'b10, 2'b01, 0, 31);
    do_cell("R3", 0, 0);
  endtask

  task automatic t_ext_change();
    pulse_chg();
    pulse_chg();
    do_cell("R3", 0, 0);
    do_cell("R3", 0, 0);
  endtask

  task automatic t_full_lead();
    req_stuff(4);
    for (int k = 0; k < 7; k++) do_cell("R4", 0, 0);
    check("R4", "countdown back to idle", m_code, 7);
  endtask

  task automatic t_short_lead();
    req_stuff(2);
    for (int k = 0; k < 5; k++) do_cell("R5", 0, 0);
    req_stuff(0);
    for (int k = 0; k < 4; k++) do_cell("R5", 0, 0);
    req_stuff(7);
    for (int k = 0; k < 7; k++) do_cell("R5", 0, 0);
  endtask

  task automatic t_ignore();
    req_stuff(3);
    do_cell("R6", 0, 0);
    req_stuff(1);
    do_cell("R6", 0, 0);
    do_cell("R6", 0, 0);
    do_cell("R6", 0, 0);
    req_stuff(2);
    do_cell("R6", 0, 0);
    do_cell("R6", 0, 0);
    coinc_lead = 3;
    do_cell("R6", 0, 0);
    for (int k = 0; k < 5; k++) do_cell("R6", 0, 0);
  endtask

  task automatic t_stream();
    do_cell("R2", 1, 0);
    do_cell("R2", 0, 1);
    do_cell("R2", 0, 1);
    do_cell("R2", 0, 0);
    @(negedge clk);
    check("R2", "valid idle after chain", int'(ovh_valid), 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    cell_req = 1'b1;
    group_id = 8'h77; grp_state = 4'b1001; symm_mode = 2'b00;
    frame_len_sel = 2'b10; clk_mode_common = 1'b1; ref_link_id = 5'd4;
    armed = 1;
    do_cell("R12", 0, 0);
    m_gid = 8'h77; m_st = 4'b1001; m_sym = 0; m_fl = 2; m_ctc = 1; m_trl = 4;
    do_cell("R12", 0, 0);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 258; k++) begin
      pulse_chg();
      do_cell("R3", 0, 0);
    end
    check("R8", "counter wrapped", int'(saw_wrap), 1);
  endtask

  initial begin
    t_reset();
    t_fields();
    t_ext_change();
    t_full_lead();
    t_short_lead();
    t_ignore();
    t_stream();
    t_latency();
    t_wrap();
    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

endmodule